// File: doc/BRIEF.md
# Dual-Issue Pairing and Pipe Steering Unit

This block sits between an in-order decode queue and four single-instance execution pipes: integer, load/store, branch and floating-point. Each cycle it looks at the two oldest queue entries. Each entry arrives already tagged with a group class. The block decides whether both entries issue together or only the oldest one. It assigns every issued entry to a pipe and tells the queue how many entries to retire.

Pairing depends only on the group classes. One flexible class can run on either the integer pipe or the load/store pipe, so two flexible entries can share a cycle. A solo class always issues by itself. The decoder supplies one dependency flag that forces single issue, and the downstream stages supply one ready signal that stops all issue. The decision is purely combinational, so the queue can apply the retire count on the same clock edge.

Top module: `pair_issue_unit`

## Requirements
- R1: While `downReady` is low, neither issue flag is set and `consumed` is 0.
- R2: Issue is strictly in order. Slot 1 issues only in a cycle where slot 0 also issues. If slot 0 is empty, nothing issues.
- R3: The two issued entries never share a pipe. Two entries of the same integer, load/store, branch or floating-point group never issue together.
- R4: Group codes are flexible=0, integer=1, load/store=2, branch=3, float=4, solo=5. Two valid entries of different groups issue together when both codes are in 0..4, `depHold` is low and `downReady` is high. This includes load/store with float, for example a sign-negate paired with a fused multiply-add.
- R5: Two flexible entries issue together. Slot 0 goes to the integer pipe and slot 1 goes to the load/store pipe.
- R6: A flexible entry goes to the load/store pipe when its partner is an integer entry. It goes to the integer pipe when its partner is a load/store entry, when its partner is a branch or float entry, and when it issues alone.
- R7: An entry with code 5, 6 or 7 always issues alone, whether it sits in slot 0 or slot 1. It is steered to the integer pipe.
- R8: When `depHold` is high, at most slot 0 issues, even if the pair of groups would be legal.
- R9: `consumed` equals the number of issue flags that are set. Every pipe code whose issue flag is clear reads 0.
- R10: The pipe codes are integer=0, load/store=1, branch=2, float=3. An issued integer, load/store, branch or float entry always gets its own group's pipe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot0Valid | input | 1 | Oldest queue entry is present |
| slot0Group | input | 3 | Group code of the oldest entry |
| slot1Valid | input | 1 | Second-oldest queue entry is present |
| slot1Group | input | 3 | Group code of the second entry |
| depHold | input | 1 | Decoder reports a dependency; forces single issue |
| downReady | input | 1 | Downstream stages can accept an issue this cycle |
| issue0Valid | output | 1 | Slot 0 issues this cycle |
| issue0Pipe | output | 2 | Pipe selected for slot 0 |
| issue1Valid | output | 1 | Slot 1 issues this cycle |
| issue1Pipe | output | 2 | Pipe selected for slot 1 |
| consumed | output | 2 | Number of entries the queue retires |

## Verification
The immediate assertions are evaluated on every input change. They check that the two issued entries never collide on one pipe, that a solo entry never shares a cycle, that issue stays in order and stops while ready is low, and that idle pipe codes read zero. Whether a legal pair is actually taken, and whether the flexible class lands on the right pipe in each context, can only be shown by the bench. The bench sweeps all 64 group-code pairs against a behavioural reference and runs a queue stream with ready and dependency stalls mixed in.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  parameter int GROUP_W = 3;
  parameter int PIPE_W  = 2;
  parameter int SLOTS   = 2;
  localparam int CNT_W  = $clog2(SLOTS + 1);

  // group class codes; any code at or above GRP_SOLO issues alone
  localparam logic [GROUP_W-1:0] GRP_FLEX = 3'd0;
  localparam logic [GROUP_W-1:0] GRP_INT  = 3'd1;
  localparam logic [GROUP_W-1:0] GRP_LS   = 3'd2;
  localparam logic [GROUP_W-1:0] GRP_BR   = 3'd3;
  localparam logic [GROUP_W-1:0] GRP_FE   = 3'd4;
  localparam logic [GROUP_W-1:0] GRP_SOLO = 3'd5;

  typedef enum logic [PIPE_W-1:0] {
    PIPE_INT = 2'd0,
    PIPE_LS  = 2'd1,
    PIPE_BR  = 2'd2,
    PIPE_FE  = 2'd3
  } pipe_e;

  // strobes from the pairing control to the steering datapath
  typedef struct packed {
    logic issueFirst;
    logic issueSecond;
    logic firstToLs;
    logic secondToLs;
  } issue_strobe_t;
endpackage

// File: rtl/pair_issue_ctrl.sv
module pair_issue_ctrl
  import pair_issue_pkg::*;
(
  input  logic               slot0Valid,
  input  logic [GROUP_W-1:0] slot0Group,
  input  logic               slot1Valid,
  input  logic [GROUP_W-1:0] slot1Group,
  input  logic               depHold,
  input  logic               downReady,
  output issue_strobe_t      strobes
);
  logic soloA, soloB, sameGroup, groupsFit;

  always_comb begin
    soloA     = (slot0Group >= GRP_SOLO);
    soloB     = (slot1Group >= GRP_SOLO);
    sameGroup = (slot0Group == slot1Group);
    // same-group pairs only allowed for the flexible class
    groupsFit = !soloA && !soloB && (!sameGroup || (slot0Group == GRP_FLEX));

    strobes.issueFirst  = slot0Valid && downReady;
    strobes.issueSecond = strobes.issueFirst && slot1Valid && !depHold && groupsFit;
    // flexible entry yields the integer pipe only to an integer partner,
    // and the younger of two flexible entries takes load/store
    strobes.firstToLs   = strobes.issueSecond && (slot0Group == GRP_FLEX) &&
                          (slot1Group == GRP_INT);
    strobes.secondToLs  = strobes.issueSecond && (slot1Group == GRP_FLEX) &&
                          ((slot0Group == GRP_INT) || (slot0Group == GRP_FLEX));
  end

  always_comb begin
    if (!downReady) begin
      assert_ready_blocks_R1: assert (!strobes.issueFirst && !strobes.issueSecond)
        else $error("issue while downstream not ready");
    end
    if (strobes.issueSecond) begin
      assert_in_order_R2: assert (strobes.issueFirst && slot0Valid)
        else $error("second issued without first");
      assert_solo_alone_R7: assert (slot0Group < GRP_SOLO && slot1Group < GRP_SOLO)
        else $error("solo entry shared a cycle");
      assert_dep_single_R8: assert (!depHold)
        else $error("pair issued under dependency hold");
    end
  end
endmodule

// File: rtl/pair_issue_steer.sv
module pair_issue_steer
  import pair_issue_pkg::*;
(
  input  issue_strobe_t      strobes,
  input  logic [GROUP_W-1:0] slot0Group,
  input  logic [GROUP_W-1:0] slot1Group,
  output logic               issue0Valid,
  output logic [PIPE_W-1:0]  issue0Pipe,
  output logic               issue1Valid,
  output logic [PIPE_W-1:0]  issue1Pipe,
  output logic [CNT_W-1:0]   consumed
);
  logic [GROUP_W-1:0] grpArr  [SLOTS];
  logic               actArr  [SLOTS];
  logic               toLsArr [SLOTS];
  pipe_e              pipeArr [SLOTS];

  always_comb begin
    grpArr[0]  = slot0Group;
    grpArr[1]  = slot1Group;
    actArr[0]  = strobes.issueFirst;
    actArr[1]  = strobes.issueSecond;
    toLsArr[0] = strobes.firstToLs;
    toLsArr[1] = strobes.secondToLs;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_lane
    always_comb begin
      if (!actArr[s]) begin
        pipeArr[s] = PIPE_INT;
      end else begin
        unique case (grpArr[s])
          GRP_INT:  pipeArr[s] = PIPE_INT;
          GRP_LS:   pipeArr[s] = PIPE_LS;
          GRP_BR:   pipeArr[s] = PIPE_BR;
          GRP_FE:   pipeArr[s] = PIPE_FE;
          GRP_FLEX: pipeArr[s] = toLsArr[s] ? PIPE_LS : PIPE_INT;
          default:  pipeArr[s] = PIPE_INT;
        endcase
      end
    end
  end

  always_comb begin
    issue0Valid = actArr[0];
    issue1Valid = actArr[1];
    issue0Pipe  = pipeArr[0];
    issue1Pipe  = pipeArr[1];
    consumed    = CNT_W'(actArr[0]) + CNT_W'(actArr[1]);
  end

  always_comb begin
    if (strobes.issueSecond) begin
      assert_distinct_pipes_R3: assert (pipeArr[0] != pipeArr[1])
        else $error("two issued entries on one pipe");
    end
    if (strobes.issueSecond && slot0Group == GRP_FLEX && slot1Group == GRP_FLEX) begin
      assert_flex_pair_lanes_R5: assert (pipeArr[0] == PIPE_INT && pipeArr[1] == PIPE_LS)
        else $error("flexible pair misplaced");
    end
    if (!strobes.issueSecond) begin
      assert_idle_pipe_zero_R9: assert (issue1Pipe == '0)
        else $error("idle lane pipe not zero");
    end
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_issue_pkg::*;
(
  input  logic               slot0Valid,
  input  logic [GROUP_W-1:0] slot0Group,
  input  logic               slot1Valid,
  input  logic [GROUP_W-1:0] slot1Group,
  input  logic               depHold,
  input  logic               downReady,
  output logic               issue0Valid,
  output logic [PIPE_W-1:0]  issue0Pipe,
  output logic               issue1Valid,
  output logic [PIPE_W-1:0]  issue1Pipe,
  output logic [CNT_W-1:0]   consumed
);
  issue_strobe_t strobes;

  pair_issue_ctrl ctrl_i (
    .slot0Valid (slot0Valid),
    .slot0Group (slot0Group),
    .slot1Valid (slot1Valid),
    .slot1Group (slot1Group),
    .depHold    (depHold),
    .downReady  (downReady),
    .strobes    (strobes)
  );

  pair_issue_steer steer_i (
    .strobes     (strobes),
    .slot0Group  (slot0Group),
    .slot1Group  (slot1Group),
    .issue0Valid (issue0Valid),
    .issue0Pipe  (issue0Pipe),
    .issue1Valid (issue1Valid),
    .issue1Pipe  (issue1Pipe),
    .consumed    (consumed)
  );
endmodule

// File: tb/pair_issue_unit_tb_top.sv
`timescale 1ns/1ps
module pair_issue_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       slot0Valid = 1'b0, slot1Valid = 1'b0, depHold = 1'b0, downReady = 1'b0;
  logic [2:0] slot0Group = '0, slot1Group = '0;
  logic       issue0Valid, issue1Valid;
  logic [1:0] issue0Pipe, issue1Pipe, consumed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pair_issue_unit dut_i (
    .slot0Valid(slot0Valid), .slot0Group(slot0Group),
    .slot1Valid(slot1Valid), .slot1Group(slot1Group),
    .depHold(depHold), .downReady(downReady),
    .issue0Valid(issue0Valid), .issue0Pipe(issue0Pipe),
    .issue1Valid(issue1Valid), .issue1Pipe(issue1Pipe),
    .consumed(consumed)
  );

  // expected pipe of a fixed-pipe group; flexible and solo start on integer
  function automatic int homePipe(int g);
    case (g)
      2: return 1;
      3: return 2;
      4: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic refModel(input bit v0, v1, input int g0, g1, input bit dep, rdy,
                          output int e0, e1, p0, p1, cnt);
    bit legal;
    legal = (g0 < 5) && (g1 < 5) && ((g0 != g1) || (g0 == 0));
    e0 = (v0 && rdy) ? 1 : 0;
    e1 = (e0 == 1 && v1 && !dep && legal) ? 1 : 0;
    p0 = (e0 == 1) ? homePipe(g0) : 0;
    p1 = (e1 == 1) ? homePipe(g1) : 0;
    if (e1 == 1 && p0 == p1) begin
      if (g1 == 0) p1 = 1;
      else if (g0 == 0) p0 = 1;
    end
    cnt = e0 + e1;
  endtask

  function automatic string scenarioTag(bit v0, int g0, int g1, bit dep, bit rdy);
    if (!rdy) return "R1";
    if (!v0) return "R2";
    if (g0 >= 5 || g1 >= 5) return "R7";
    if (dep) return "R8";
    if (g0 == 0 && g1 == 0) return "R5";
    if (g0 == 0 || g1 == 0) return "R6";
    if (g0 == g1) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (v0=%0d g0=%0d v1=%0d g1=%0d dep=%0d rdy=%0d)",
               tag, what, act, exp, slot0Valid, slot0Group, slot1Valid, slot1Group,
               depHold, downReady);
    end
  endtask

  task automatic compareAll();
    int e0, e1, p0, p1, cnt;
    string tag;
    refModel(slot0Valid, slot1Valid, int'(slot0Group), int'(slot1Group), depHold, downReady,
             e0, e1, p0, p1, cnt);
    tag = scenarioTag(slot0Valid, int'(slot0Group), int'(slot1Group), depHold, downReady);
    chk(tag, "issue0Valid", int'(issue0Valid), e0);
    chk(tag, "issue1Valid", int'(issue1Valid), e1);
    chk((e0 == 1 && slot0Group inside {[1:4]}) ? "R10" : tag, "issue0Pipe", int'(issue0Pipe), p0);
    chk((e1 == 1 && slot1Group inside {[1:4]}) ? "R10" : tag, "issue1Pipe", int'(issue1Pipe), p1);
    chk("R9", "consumed", int'(consumed), cnt);
  endtask

  task automatic applyStep(bit v0, int g0, bit v1, int g1, bit dep, bit rdy);
    @(posedge clk);
    #1;
    slot0Valid = v0; slot0Group = 3'(g0);
    slot1Valid = v1; slot1Group = 3'(g1);
    depHold = dep; downReady = rdy;
    @(negedge clk);
    compareAll();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stimulus
    int stream[$];
    int cyc;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // idle: nothing present, ready low (R2, R1)
    @(negedge clk);
    compareAll();

    // full sweep of every ordered group-code pair under every control combination
    for (int g0 = 0; g0 < 8; g0++)
      for (int g1 = 0; g1 < 8; g1++)
        for (int ctl = 0; ctl < 16; ctl++)
          applyStep(ctl[0], g0, ctl[1], g1, ctl[2], ctl[3]);

    // queue stream: pop what the reference retires each cycle
    stream = '{1, 2, 0, 0, 4, 2, 3, 5, 1, 0, 2, 0, 3, 3, 4, 4, 5, 5, 0, 1,
               6, 7, 2, 4, 0, 3, 4, 0, 1, 1, 2, 2};
    cyc = 0;
    while (stream.size() > 0 && cyc < 500) begin
      int e0, e1, p0, p1, cnt;
      bit rdy, dep;
      rdy = (cyc % 5) != 4;
      dep = (cyc % 7) == 3;
      applyStep(1'b1, stream[0], stream.size() > 1, (stream.size() > 1) ? stream[1] : 0,
                dep, rdy);
      refModel(1'b1, stream.size() > 1, stream[0], (stream.size() > 1) ? stream[1] : 0,
               dep, rdy, e0, e1, p0, p1, cnt);
      for (int k = 0; k < cnt; k++) void'(stream.pop_front());
      cyc++;
    end
    chk("R2", "stream drained", stream.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule